// File: doc/BRIEF.md
# Programmable-Length Serial Peripheral Master

This block is a byte-oriented SPI master engine. Software sees three byte-wide registers on a simple synchronous register port. The first sets the serial clock rate and polarity. The second holds the outgoing byte and, after a transfer, the bits captured from the slave. The third is the command and status register. It sets the transfer length and the resting level of the data output, starts a transfer, and reports when the engine is busy.

To run a transfer, software programs the clock settings, loads a byte and sets the length, then writes the start bit. The engine then produces the serial clock at the core clock divided by 4×(N+1). It drives the data bits out most significant first, starting at bit B of the data register, and captures the input line into the low end of that same register. When the final bit has been captured, the engine clears the start bit and returns both serial lines to their resting levels. The byte received can then be read. Chip select is generated elsewhere.

Top module: `spi_shift_engine`

## Requirements
- R1: The configuration register is at address 0, the data register at address 1 and the command register at address 2. After reset all three read 00h. With polarity 0 the serial clock idles high, and the data output idles low.
- R2: Each half-period of the serial clock lasts 2×(N+1) core cycles, where N is configuration bits 3:0. The first active half starts in the cycle after the start write.
- R3: Configuration bit 7 selects polarity. With 1, the clock idles low and its active half is high. With 0, the clock idles high and its active half is low.
- R4: Writing command bit 7 = 1 while idle starts a transfer. That bit then reads 1 until the transfer completes, and 0 afterwards.
- R5: A transfer moves B+1 bits, where B is command bits 6:4. The serial clock makes exactly 2×(B+1) level changes.
- R6: Bits leave most significant first. The first bit is data bit B, and each later bit is the next lower bit of the byte as loaded.
- R7: During a transfer the data output changes only on leading (idle-to-active) clock edges.
- R8: On each trailing edge the input line is sampled, and the data register becomes (data shifted left by one, input bit in bit 0), truncated to 8 bits.
- R9: Command bit 3 is a read-only busy flag that reads 1 for the whole transfer.
- R10: While busy, writes to the configuration, data and command registers are ignored, and a second start has no effect.
- R11: At the final trailing edge the transfer ends. The clock rests at its idle level, and the data output moves to the level in command bit 0 (0 low, 1 high).
- R12: Configuration bits 6:4 and command bits 2:1 always read 0 whatever is written to them, and address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest case to reach is a register write that lands in the middle of a transfer, particularly a second start or a clock-rate change arriving between half-periods at the slowest divider. The stimulus does this by issuing writes to all three registers right after a start with N=15 and B=7. It then checks that the transfer keeps its original timing and length. Every run also steps the read address through all registers on each cycle while busy, so the start, busy and shifting data bits are compared at every half-period boundary, including the final trailing edge where busy drops.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 4;
    localparam int LEN_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ADDR_CFG  = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } reg_sel_e;

    localparam int CFG_POL_BIT  = 7;
    localparam int CTL_GO_BIT   = 7;
    localparam int CTL_LEN_LSB  = 4;
    localparam int CTL_BUSY_BIT = 3;
    localparam int CTL_IDLE_BIT = 0;
endpackage

// File: rtl/spi_eng_halfper.sv
module spi_eng_halfper #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    // 2*(N+1)-1 == {N,1}
    assign last   = {div_i, 1'b1};
    assign tick_o = run_i && (cnt_q == last);

    always_comb begin
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: the counter never runs past the end of a half-period
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= last));
    // R2: the count restarts after each half-period boundary
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              tick_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              act_o,
    output logic              mosi_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              busy;
        logic              act;
        logic              mosi;
        logic [DATA_W-1:0] sh;
        logic [LEN_W-1:0]  left;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load_i) st_d.sh = load_data_i;
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.act  = 1'b1;
                st_d.mosi = st_q.sh[len_i];
                st_d.left = len_i;
            end
        end else if (tick_i) begin
            if (st_q.act) begin
                // trailing edge: capture input at the LSB
                st_d.act = 1'b0;
                st_d.sh  = {st_q.sh[DATA_W-2:0], miso_i};
                if (st_q.left == '0) st_d.busy = 1'b0;
                else                 st_d.left = st_q.left - 1'b1;
            end else begin
                // leading edge: present next bit
                st_d.act  = 1'b1;
                st_d.mosi = st_q.sh[len_i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign act_o  = st_q.act;
    assign mosi_o = st_q.mosi;
    assign data_o = st_q.sh;

    a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.busy) |=> (st_q.busy && st_q.act));
    a_r2_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tick_i) |=> $stable(st_q.act));
    a_r7_mosi_leading: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy) && !$rose(st_q.act)) |-> $stable(st_q.mosi));
    a_r8_sample_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !(tick_i && st_q.act)) |=> $stable(st_q.sh));
    a_r11_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> !st_q.act);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sclk_o,
    output logic       mosi_o,
    input  logic       miso_i
);
    typedef struct packed {
        logic             pol;
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] len;
        logic             idle;
    } regs_t;

    regs_t r_d, r_q;

    logic              busy, act, sh_mosi, tick;
    logic              start, load;
    logic [DATA_W-1:0] shreg;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        load  = 1'b0;
        if (reg_wr && !busy) begin
            if (reg_addr == ADDR_CFG) begin
                r_d.pol = reg_wdata[CFG_POL_BIT];
                r_d.div = reg_wdata[DIV_W-1:0];
            end
            if (reg_addr == ADDR_DATA) load = 1'b1;
            if (reg_addr == ADDR_CTRL) begin
                r_d.len  = reg_wdata[CTL_LEN_LSB +: LEN_W];
                r_d.idle = reg_wdata[CTL_IDLE_BIT];
                start    = reg_wdata[CTL_GO_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    spi_eng_halfper #(.DIV_W(DIV_W)) i_halfper (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (r_q.div),
        .tick_o (tick)
    );

    spi_eng_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .len_i       (r_d.len),
        .load_i      (load),
        .load_data_i (reg_wdata),
        .tick_i      (tick),
        .miso_i      (miso_i),
        .busy_o      (busy),
        .act_o       (act),
        .mosi_o      (sh_mosi),
        .data_o      (shreg)
    );

    assign sclk_o = r_q.pol ? act : !act;
    assign mosi_o = busy ? sh_mosi : r_q.idle;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[CFG_POL_BIT]  = r_q.pol;
                reg_rdata[DIV_W-1:0]    = r_q.div;
            end
            ADDR_DATA: reg_rdata = shreg;
            ADDR_CTRL: begin
                reg_rdata[CTL_GO_BIT]               = busy;
                reg_rdata[CTL_LEN_LSB +: LEN_W]     = r_q.len;
                reg_rdata[CTL_BUSY_BIT]             = busy;
                reg_rdata[CTL_IDLE_BIT]             = r_q.idle;
            end
            default: reg_rdata = '0;
        endcase
    end

    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == ADDR_CFG) |=> $stable(r_q));
    a_r10_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == ADDR_CTRL) |=> $stable(r_q));
    a_r3_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_o == !r_q.pol));
endmodule

// File: tb/test_spi_shift_engine.sv
module test_spi_shift_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sclk_o, mosi_o;
    logic       miso_i = 1'b0;

    always #10 clk = ~clk;

    spi_shift_engine i_spi_shift_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_pol, m_div, m_dat, m_len, m_idle, m_busy, m_act, m_mosi, m_e, m_h, m_k;

    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #3;
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso_i <= lfsr[0];
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = 0; m_div = 0; m_dat = 0; m_len = 0; m_idle = 0;
            m_busy = 0; m_act = 0; m_mosi = 0; m_e = 0;
        end else if (m_busy != 0) begin
            m_e++;
            m_h = 2 * (m_div + 1);
            if (m_e % m_h == 0) begin
                m_k = m_e / m_h;
                if (m_k % 2 == 1) begin
                    m_dat = ((m_dat << 1) | int'(miso_i)) & 255;
                    m_act = 0;
                    if (m_k == 2 * (m_len + 1) - 1) m_busy = 0;
                end else begin
                    m_act  = 1;
                    m_mosi = (m_dat >> m_len) & 1;
                end
            end
        end else if (reg_wr) begin
            case (reg_addr)
                2'd0: begin m_pol = reg_wdata[7]; m_div = reg_wdata[3:0]; end
                2'd1: m_dat = reg_wdata;
                2'd2: begin
                    m_len  = reg_wdata[6:4];
                    m_idle = reg_wdata[0];
                    if (reg_wdata[7]) begin
                        m_busy = 1; m_act = 1; m_e = 0;
                        m_mosi = (m_dat >> m_len) & 1;
                    end
                end
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp_rd;
            chk("R2,R3 sclk", {7'd0, sclk_o}, 8'((m_pol != 0) ? m_act : (m_act == 0)));
            chk("R6,R7,R11 mosi", {7'd0, mosi_o}, 8'((m_busy != 0) ? m_mosi : m_idle));
            case (reg_addr)
                2'd0: exp_rd = 8'((m_pol << 7) | m_div);
                2'd1: exp_rd = 8'(m_dat);
                2'd2: exp_rd = 8'((m_busy << 7) | (m_len << 4) | (m_busy << 3) | m_idle);
                default: exp_rd = 8'h00;
            endcase
            chk("R4,R8,R9,R12 rdata", reg_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    // run one transfer and count serial clock level changes (R5)
    task automatic xfer(input logic [7:0] cfg, input logic [7:0] dat, input logic [7:0] ctl,
                        input bit poke);
        int edges = 0;
        int guard = 0;
        logic prev;
        wr(2'd0, cfg);
        wr(2'd1, dat);
        prev = sclk_o;
        wr(2'd2, ctl | 8'h80);
        if (poke) begin
            // R10: all of these must be ignored
            wr(2'd0, 8'h8F);
            wr(2'd1, 8'h3C);
            wr(2'd2, 8'hA0);
        end
        while (m_busy != 0 && guard < 2000) begin
            @(negedge clk);
            if (sclk_o !== prev) edges++;
            prev = sclk_o;
            @(posedge clk); #2;
            reg_addr = reg_addr + 2'd1;
            guard++;
        end
        @(negedge clk);
        if (sclk_o !== prev) edges++;
        if (!poke) chk("R5 clock edges", 8'(edges), 8'(2 * (ctl[6:4] + 1)));
        @(posedge clk); #2;
        reg_addr = 2'd1;
        @(negedge clk);
        chk("R8 received byte", reg_rdata, 8'(m_dat));
        chk("R11 idle level", {7'd0, mosi_o}, {7'd0, ctl[0]});
        reg_addr = 2'd2;
        @(negedge clk);
        chk("R4 start cleared", reg_rdata & 8'h88, 8'h00);
        if (poke) begin
            chk("R10 ctrl kept", reg_rdata, ctl & 8'h71);
            reg_addr = 2'd0;
            @(negedge clk);
            chk("R10 cfg kept", reg_rdata, cfg & 8'h8F);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            @(negedge clk);
            chk("R1 reset register", reg_rdata, 8'h00);
        end
        chk("R1 reset sclk", {7'd0, sclk_o}, 8'h01);
        chk("R1 reset mosi", {7'd0, mosi_o}, 8'h00);
        @(posedge clk); #2;

        // R12: reserved bits read zero
        wr(2'd0, 8'hF5);
        reg_addr = 2'd0; @(negedge clk);
        chk("R12 cfg reserved", reg_rdata, 8'h85);
        wr(2'd2, 8'h07);
        reg_addr = 2'd2; @(negedge clk);
        chk("R12 ctrl reserved", reg_rdata, 8'h01);
        reg_addr = 2'd3; @(negedge clk);
        chk("R12 unused address", reg_rdata, 8'h00);

        xfer(8'h80, 8'hA5, 8'h70, 1'b0);  // fastest, 8 bits, normal clock
        xfer(8'h03, 8'h01, 8'h01, 1'b0);  // 1 bit, inverted clock, idle high
        xfer(8'h82, 8'h5A, 8'h41, 1'b0);  // 5 bits
        xfer(8'h01, 8'hC3, 8'h20, 1'b0);  // 3 bits
        xfer(8'h8F, 8'h96, 8'h71, 1'b1);  // slowest, 8 bits, writes while busy
        xfer(8'h00, 8'hFF, 8'h10, 1'b0);  // 2 bits
        xfer(8'h85, 8'h3E, 8'h60, 1'b0);  // 7 bits

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule